// File: doc/BRIEF.md
# Majority-Multiplexed Pipeline with Periodic Restoration and Final Vote

This block carries a logic value as a bundle of N redundant lines through a chain of D majority stages. Every stage has an executive layer of N three-input majority gates. Gate j of a stage takes line j of the previous stage's bundle and line j of two external side bundles. The first stage instead combines three primary input bundles. A restorative layer of N further majority gates is inserted only after depths that are whole multiples of the parameter K, and K = 0 means the chain never restores. The bundle is never collapsed between stages. A single threshold vote over the final bundle produces the one-bit result.

Each gate output can be flipped through a fault-injection mask, so a test environment can model faulty gates and compare the voted bit against the fault-free nominal value. Stage boundaries are registered and carry a valid bit. Input and output use valid/ready. The whole chain advances only when the output slot is empty or being taken. When `out_valid` is high and `out_ready` is low, every stage holds its contents and `in_ready` is low. `out_bit` then stays constant until the consumer takes it.

Top module: `maj_mux_chain`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: A bundle accepted on a rising edge (`in_valid` and `in_ready` both high) produces `out_valid` high after exactly D rising edges, counting the accepting edge. It is not valid after D-1 edges.
- R3: Depth 1 line j is maj(in_a[j], in_b[j], in_c[j]). Depth d > 1 line j is maj(prev[j], side_b[(d-2)*N+j], side_c[(d-2)*N+j]). Here maj is two-of-three.
- R4: When K != 0 and the depth d is a multiple of K, the executive result x is replaced by a restored bundle. Line j of that bundle is maj(x[j], x[(j+1) mod N], x[(j+2) mod N]). When K = 0, no depth restores.
- R5: Bit i*N+j of `fault_exe` inverts executive gate j of depth i+1. Bit r*N+j of `fault_res` inverts restorative gate j at depth (r+1)*K. With K = 0, `fault_res` has no effect on `out_bit`.
- R6: `out_bit` is 1 exactly when the number of ones in the final bundle exceeds floor(N/2). For odd N this means at least ceil(N/2) ones. An exact half on even N gives 0.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_bit` hold their values on the next cycle.
- R8: In the worst case, `in_a` and `in_b` are all ones, `in_c` is all zeros, every `side_b` is all ones and every `side_c` is all zeros. With at most two executive faults and one restorative fault in total, `out_bit` is then 1.
- R9: The number of accepted bundles not yet delivered never exceeds D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bundles present |
| in_ready | output | 1 | Chain accepts a bundle this cycle |
| in_a | input | N | First primary input bundle |
| in_b | input | N | Second primary input bundle |
| in_c | input | N | Third primary input bundle |
| side_b | input | (D-1)*N | Second operand bundles for depths 2..D |
| side_c | input | (D-1)*N | Third operand bundles for depths 2..D |
| fault_exe | input | D*N | Inversion mask for executive gates |
| fault_res | input | NRES*N | Inversion mask for restorative gates, NRES = D/K (1 if K = 0) |
| out_valid | output | 1 | Voted result present |
| out_ready | input | 1 | Consumer takes the result |
| out_bit | output | 1 | Threshold vote of the final bundle |

## Verification
Uniform bundles sweep all eight nominal combinations of the three primary inputs and all four side-bundle combinations without faults. This separates the majority selection at depth 1 from the pass-through or override behaviour of later depths. Random bundles with random fault masks are compared bit-exactly with an arithmetic model, run on both a restoring instance and a non-restoring instance. These runs tell apart the rotation offsets, the placement of restoring depths and the mask indexing. The worst-case split of two high and one low is run under a few injected faults to show that the vote recovers the nominal value. Faults flipped on exactly five or six lines of the final executive layer probe the vote threshold.

// File: rtl/maj_mux_pkg.sv
`timescale 1ns/1ps
package maj_mux_pkg;
  // two-of-three over whole bundles
  function automatic logic [63:0] maj3_vec(input logic [63:0] p, input logic [63:0] q,
                                           input logic [63:0] r);
    return (p & q) | (p & r) | (q & r);
  endfunction
endpackage

// File: rtl/maj_layer.sv
`timescale 1ns/1ps
module maj_layer #(
  parameter int N = 11
) (
  input  logic [N-1:0] x0,
  input  logic [N-1:0] x1,
  input  logic [N-1:0] x2,
  input  logic [N-1:0] flip,
  output logic [N-1:0] y
);
  import maj_mux_pkg::*;
  logic [63:0] m;
  assign m = maj3_vec(64'(x0), 64'(x1), 64'(x2));
  assign y = m[N-1:0] ^ flip;
endmodule

// File: rtl/bundle_vote.sv
`timescale 1ns/1ps
module bundle_vote #(
  parameter int N = 11
) (
  input  logic [N-1:0] lines,
  output logic         hit
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt;
  always_comb begin
    cnt = '0;
    for (int j = 0; j < N; j++) cnt = cnt + CW'(lines[j]);
  end
  // strictly more than half: ties on even N give low
  assign hit = cnt > CW'(N / 2);
endmodule

// File: rtl/maj_mux_chain.sv
`timescale 1ns/1ps
module maj_mux_chain #(
  parameter int N = 11,
  parameter int D = 10,
  parameter int K = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [N-1:0]                in_a,
  input  logic [N-1:0]                in_b,
  input  logic [N-1:0]                in_c,
  input  logic [(D-1)*N-1:0]          side_b,
  input  logic [(D-1)*N-1:0]          side_c,
  input  logic [D*N-1:0]              fault_exe,
  input  logic [((K == 0) ? 1 : D / ((K == 0) ? 1 : K))*N-1:0] fault_res,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_bit
);
  localparam int KS   = (K == 0) ? 1 : K;
  localparam int NRES = (K == 0) ? 1 : D / KS;

  logic [N-1:0] stq [D];
  logic [N-1:0] nxt [D];
  logic [D-1:0] vq;
  logic         adv;

  assign out_valid = vq[D-1];
  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv;

  for (genvar i = 0; i < D; i++) begin : g_stage
    localparam bit RESTORE = (K != 0) && (((i + 1) % KS) == 0);
    logic [N-1:0] s0, s1, s2, ex;
    if (i == 0) begin : g_head
      assign s0 = in_a;
      assign s1 = in_b;
      assign s2 = in_c;
    end else begin : g_body
      assign s0 = stq[i-1];
      assign s1 = side_b[(i-1)*N +: N];
      assign s2 = side_c[(i-1)*N +: N];
    end
    maj_layer #(.N(N)) u_exe (
      .x0(s0), .x1(s1), .x2(s2), .flip(fault_exe[i*N +: N]), .y(ex));
    if (RESTORE) begin : g_res
      localparam int R = (i + 1) / KS - 1;
      logic [N-1:0] rot1, rot2, rs;
      assign rot1 = {ex[0], ex[N-1:1]};
      assign rot2 = {ex[1:0], ex[N-1:2]};
      maj_layer #(.N(N)) u_res (
        .x0(ex), .x1(rot1), .x2(rot2), .flip(fault_res[R*N +: N]), .y(rs));
      assign nxt[i] = rs;
    end else begin : g_pass
      assign nxt[i] = ex;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int i = 0; i < D; i++) stq[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vq <= '0;
    else if (adv) vq <= {vq[D-2:0], in_valid};
  end

  bundle_vote #(.N(N)) u_vote (.lines(stq[D-1]), .hit(out_bit));

  if (NRES < 1) begin : g_bad
    initial $error("bad restoration count");
  end
endmodule

// File: rtl/maj_mux_chain_chk.sv
`timescale 1ns/1ps
module maj_mux_chain_chk #(
  parameter int D = 10
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit
);
  localparam int W = $clog2(D + 2) + 1;
  logic [W-1:0] occ;
  logic         seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ  <= '0;
      seen <= 1'b0;
    end else begin
      seen <= 1'b1;
      occ  <= occ + W'(in_valid && in_ready) - W'(out_valid && out_ready);
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (seen && out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

  assert_occupancy_R9: assert property (@(posedge clk) disable iff (rst)
    occ <= W'(D));

  assert_no_phantom_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (occ != '0));

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (!out_valid && in_ready));
endmodule

bind maj_mux_chain maj_mux_chain_chk #(.D(D)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit));

// File: tb/test_maj_mux_chain.sv
`timescale 1ns/1ps
module test_maj_mux_chain;
  localparam int N = 11;
  localparam int D = 10;
  localparam int K = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [N-1:0] a = '0, b = '0, c = '0;
  logic [(D-1)*N-1:0] sb = '0, sc = '0;
  logic [D*N-1:0] fe = '0;
  logic [(D/K)*N-1:0] fr = '0;
  logic [N-1:0] fr0 = '0;
  logic ir3, ov3, ob3, ir0, ov0, ob0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  maj_mux_chain #(.N(N), .D(D), .K(K)) i_maj_mux_chain (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir3),
    .in_a(a), .in_b(b), .in_c(c), .side_b(sb), .side_c(sc),
    .fault_exe(fe), .fault_res(fr), .out_valid(ov3), .out_ready(out_ready),
    .out_bit(ob3));

  maj_mux_chain #(.N(N), .D(D), .K(0)) i_maj_mux_chain_nr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir0),
    .in_a(a), .in_b(b), .in_c(c), .side_b(sb), .side_c(sc),
    .fault_exe(fe), .fault_res(fr0), .out_valid(ov0), .out_ready(out_ready),
    .out_bit(ob0));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mj(input logic [N-1:0] p, input logic [N-1:0] q,
                                      input logic [N-1:0] r);
    logic [N-1:0] o;
    for (int j = 0; j < N; j++) o[j] = (int'(p[j]) + int'(q[j]) + int'(r[j])) >= 2;
    return o;
  endfunction

  // arithmetic model of R3..R6
  function automatic bit model(input int kk);
    logic [N-1:0] x, y;
    int r = 0;
    for (int i = 0; i < D; i++) begin
      if (i == 0) x = mj(a, b, c);
      else x = mj(x, sb[(i-1)*N +: N], sc[(i-1)*N +: N]);
      x = x ^ fe[i*N +: N];
      if (kk != 0 && ((i + 1) % kk) == 0) begin
        for (int j = 0; j < N; j++)
          y[j] = (int'(x[j]) + int'(x[(j+1)%N]) + int'(x[(j+2)%N])) >= 2;
        y = y ^ fr[r*N +: N];
        r++;
        x = y;
      end
    end
    return $countones(x) > N / 2;
  endfunction

  function automatic logic [N-1:0] rnd_bundle();
    logic [N-1:0] v;
    for (int j = 0; j < N; j++) v[j] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  // one transfer; checks latency and both results
  task automatic xfer(input bit e3, input bit e0, input string req);
    @(negedge clk); in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    repeat (D - 2) @(negedge clk);
    chk(!ov3 && !ov0, "R2 not valid after D-1 edges", int'(ov3 | ov0), 0);
    @(negedge clk);
    chk(ov3 && ov0, "R2 valid after D edges", int'(ov3 & ov0), 1);
    chk(ob3 == e3, {req, " restoring"}, int'(ob3), int'(e3));
    chk(ob0 == e0, {req, " non-restoring"}, int'(ob0), int'(e0));
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ov3 && !ov0, "R1 out_valid in reset", int'(ov3 | ov0), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ov3 && ir3 && ir0, "R1 ready after reset", int'(ir3 & ir0), 1);

    // R3: uniform sweep, fault-free
    for (int m = 0; m < 32; m++) begin
      a = {N{m[0]}}; b = {N{m[1]}}; c = {N{m[2]}};
      sb = {(D-1)*N{m[3]}}; sc = {(D-1)*N{m[4]}};
      fe = '0; fr = '0;
      xfer(model(K), model(0), "R3 uniform sweep");
    end

    // R4 R5: random bundles and masks versus model
    for (int t = 0; t < 150; t++) begin
      a = rnd_bundle(); b = rnd_bundle(); c = rnd_bundle();
      for (int i = 0; i < D - 1; i++) begin
        sb[i*N +: N] = rnd_bundle(); sc[i*N +: N] = rnd_bundle();
      end
      for (int i = 0; i < D; i++) fe[i*N +: N] = (t % 3 == 0) ? rnd_bundle() : '0;
      for (int i = 0; i < D / K; i++) fr[i*N +: N] = rnd_bundle();
      fr0 = rnd_bundle();
      xfer(model(K), model(0), "R4 R5 random masks");
    end

    // R8: worst-case split with a few faults; nominal is high
    a = '1; b = '1; c = '0; sb = '1; sc = '0;
    for (int t = 0; t < 60; t++) begin
      fe = '0; fr = '0;
      fe[$urandom_range(0, D*N - 1)] = 1'b1;
      fe[$urandom_range(0, D*N - 1)] = 1'b1;
      fr[$urandom_range(0, (D/K)*N - 1)] = 1'b1;
      xfer(1'b1, 1'b1, "R8 worst case recovers");
    end

    // R5: restorative mask has no effect without restoration
    fe = '0; fr = '0; fr0 = '1;
    xfer(1'b1, 1'b1, "R5 unused restorative mask");

    // R6: threshold on last depth (depth 10 does not restore with K=3)
    fr0 = '0;
    fe = '0; fe[(D-1)*N +: N] = N'(11'b00000011111);
    xfer(1'b1, 1'b1, "R6 six ones vote high");
    fe[(D-1)*N +: N] = N'(11'b00000111111);
    xfer(1'b0, 1'b0, "R6 five ones vote low");
    fe = '0;

    // R7: back-pressure
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    repeat (D - 1) @(negedge clk);
    chk(ov3 && !ir3, "R7 stalled output", int'(ov3 & !ir3), 1);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(ov3 && ob3 && !ir3 && !ir0, "R7 hold while stalled", int'(ob3), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(!ov3 && !ov0, "R7 drained after ready", int'(ov3 | ov0), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule